// File: doc/BRIEF.md
# Path RDI Persistence Detector

This block sits behind the byte extractor of a high-order path terminator and looks at the path status byte once per frame. The extractor asserts a strobe together with the byte. From the byte, the block takes the remote defect indication (RDI) bits and passes them through a persistence filter. The filtered status changes only when the same RDI code has been seen in a configurable number of consecutive status bytes. The filter ignores single-frame glitches and any run of differing codes shorter than the threshold.

Two controls come from the configuration logic, which resets them to a run length of 5 and enhanced mode. A 2-bit select picks the run length from the set 3, 5, 10 or 16. A mode bit chooses between two ways of comparing:
- **Enhanced mode:** the three RDI bits are compared as a code.
- **Single-bit mode:** only the primary RDI bit is compared.

Separately from the filter, the four low bits of the most recent status byte (the RDI bits and the spare bit) are presented unfiltered.

Top module: `path_rdi_filter`

## Requirements
- R1: After a synchronous reset, `rdi_status` is 3'b000 and `rdi_raw` is 4'b0000.
- R2: One clock after each strobed byte, `rdi_raw` equals bits [3:0] of that byte: bit 3 is the primary RDI bit, bits 2:1 are the enhanced RDI bits and bit 0 is the spare bit.
- R3: `persist_sel` gives the run length needed: 2'b00 means 3, 2'b01 means 5, 2'b10 means 10, and 2'b11 means 16 consecutive strobed bytes with an identical code.
- R4: `rdi_status` takes the new code in the clock right after the strobe of the byte that completes the run. It does not change after the byte before that one.
- R5: A strobed byte whose code differs from the code of the preceding strobed byte restarts the run at 1, so the run length must be met again in full.
- R6: With `enh_mode`=1, the code is byte bits [3:1], and `rdi_status[2:0]` reflects byte bits [3:1] in the same order.
- R7: With `enh_mode`=0, the code is byte bit 3 alone, a change in byte bits [2:1] neither breaks nor restarts a run, and `rdi_status[1:0]` reads 2'b00.
- R8: The run count saturates rather than wrapping. However long a run of identical codes lasts, a different code still needs the full run length before `rdi_status` follows it.
- R9: Without a strobe, `rdi_status` and `rdi_raw` hold their values.
- R10: The run count and the held code both start from zero after reset. A first run of all-zero codes therefore counts from the first strobed byte, and `rdi_status` stays 3'b000 throughout it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| g1_valid | input | 1 | Strobe: `g1_byte` carries a new path status byte |
| g1_byte | input | 8 | Received path status byte |
| persist_sel | input | 2 | Run-length select (3/5/10/16) |
| enh_mode | input | 1 | 1 = enhanced three-bit RDI code, 0 = primary bit only |
| rdi_status | output | 3 | Filtered RDI status |
| rdi_raw | output | 4 | Unfiltered RDI bits plus spare bit of the latest byte |

## Verification
The bench finds the edge of each run length by comparing the output after the byte that completes the run with the output after the byte just before it.
- A design that compares against the wrong threshold, or that loads the status one byte late or one byte early, fails these checks.
- Runs that are broken one byte short of the threshold catch a design that keeps counting instead of restarting.
- Runs of forty identical bytes catch a counter that wraps, which would either load a later different code too early or fail to load it at all.
- In single-bit mode, the bench toggles bits 2:1 in the middle of a run. A design that still compares those bits would restart the run and miss the update.

// File: rtl/pdi_pkg.sv
package pdi_pkg;

    localparam int G1_W    = 8;
    localparam int CODE_W  = 3;
    localparam int RAW_W   = 4;
    localparam int MAX_RUN = 16;
    localparam int CNT_W   = $clog2(MAX_RUN + 1);

    typedef logic [CODE_W-1:0] rdi_code_t;
    typedef logic [CNT_W-1:0]  run_cnt_t;

    typedef struct packed {
        rdi_code_t            code;
        logic [RAW_W-1:0]     raw;
    } g1_fields_t;

    // Run length required for each select value.
    function automatic run_cnt_t run_threshold(input logic [1:0] sel);
        run_cnt_t t;
        case (sel)
            2'b00:   t = run_cnt_t'(3);
            2'b01:   t = run_cnt_t'(5);
            2'b10:   t = run_cnt_t'(10);
            default: t = run_cnt_t'(MAX_RUN);
        endcase
        return t;
    endfunction

    // Pick the compared code and the raw nibble out of the status byte.
    function automatic g1_fields_t split_g1(input logic [G1_W-1:0] b, input logic enh);
        g1_fields_t f;
        f.raw  = b[RAW_W-1:0];
        f.code = enh ? b[3:1] : {b[3], 2'b00};
        return f;
    endfunction

endpackage

// File: rtl/rdi_code_extract.sv
module rdi_code_extract
    import pdi_pkg::*;
(
    input  logic [G1_W-1:0] byte_in,
    input  logic            enh,
    output g1_fields_t      fields
);
    always_comb fields = split_g1(byte_in, enh);
endmodule

// File: rtl/rdi_run_tracker.sv
module rdi_run_tracker
    import pdi_pkg::*;
#(
    parameter int SAT = MAX_RUN
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      valid,
    input  rdi_code_t code,
    input  run_cnt_t  thr,
    output logic      qualified,
    output run_cnt_t  cnt_q
);
    localparam run_cnt_t SAT_C = run_cnt_t'(SAT);

    rdi_code_t cand_q;
    run_cnt_t  cnt_nxt;

    always_comb begin
        if (code != cand_q)
            cnt_nxt = run_cnt_t'(1);
        else if (cnt_q >= SAT_C)
            cnt_nxt = SAT_C;
        else
            cnt_nxt = cnt_q + run_cnt_t'(1);
        qualified = valid && (cnt_nxt >= thr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cand_q <= '0;
            cnt_q  <= '0;
        end else if (valid) begin
            cand_q <= code;
            cnt_q  <= cnt_nxt;
        end
    end
endmodule

// File: rtl/rdi_status_hold.sv
module rdi_status_hold
    import pdi_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  rdi_code_t code,
    input  logic      enh,
    output rdi_code_t held_q,
    output rdi_code_t status
);
    always_ff @(posedge clk) begin
        if (rst)       held_q <= '0;
        else if (load) held_q <= code;
    end

    always_comb status = enh ? held_q : {held_q[CODE_W-1], {(CODE_W-1){1'b0}}};
endmodule

// File: rtl/path_rdi_filter.sv
module path_rdi_filter
    import pdi_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            g1_valid,
    input  logic [G1_W-1:0] g1_byte,
    input  logic [1:0]      persist_sel,
    input  logic            enh_mode,
    output logic [2:0]      rdi_status,
    output logic [3:0]      rdi_raw
);
    g1_fields_t       fields;
    run_cnt_t         run_cnt;
    logic             qualified;
    rdi_code_t        held_q;
    rdi_code_t        status_w;
    logic [RAW_W-1:0] raw_q;

    rdi_code_extract u_extract (
        .byte_in (g1_byte),
        .enh     (enh_mode),
        .fields  (fields)
    );

    rdi_run_tracker #(.SAT(MAX_RUN)) u_run (
        .clk       (clk),
        .rst       (rst),
        .valid     (g1_valid),
        .code      (fields.code),
        .thr       (run_threshold(persist_sel)),
        .qualified (qualified),
        .cnt_q     (run_cnt)
    );

    rdi_status_hold u_hold (
        .clk    (clk),
        .rst    (rst),
        .load   (qualified),
        .code   (fields.code),
        .enh    (enh_mode),
        .held_q (held_q),
        .status (status_w)
    );

    always_ff @(posedge clk) begin
        if (rst)           raw_q <= '0;
        else if (g1_valid) raw_q <= fields.raw;
    end

    assign rdi_status = status_w;
    assign rdi_raw    = raw_q;
endmodule

// File: rtl/path_rdi_filter_chk.sv
module path_rdi_filter_chk
    import pdi_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            g1_valid,
    input logic [G1_W-1:0] g1_byte,
    input logic            enh_mode,
    input logic [2:0]      rdi_status,
    input logic [3:0]      rdi_raw,
    input rdi_code_t       held_q,
    input run_cnt_t        run_cnt
);
    assert_raw_follows_R2: assert property (@(posedge clk) disable iff (rst)
        g1_valid |=> rdi_raw == $past(g1_byte[3:0]));

    assert_raw_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !g1_valid |=> $stable(rdi_raw));

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !g1_valid |=> $stable(held_q));

    assert_single_bit_mask_R7: assert property (@(posedge clk) disable iff (rst)
        !enh_mode |-> rdi_status[1:0] == 2'b00);

    assert_no_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        run_cnt <= run_cnt_t'(MAX_RUN));

    assert_count_step_R5: assert property (@(posedge clk) disable iff (rst)
        g1_valid |=> (run_cnt != '0));
endmodule

bind path_rdi_filter path_rdi_filter_chk u_chk (.*);

// File: tb/sim_path_rdi_filter.sv
module sim_path_rdi_filter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       g1_valid = 1'b0;
    logic [7:0] g1_byte = '0;
    logic [1:0] persist_sel = 2'b01;
    logic       enh_mode = 1'b1;
    logic [2:0] rdi_status;
    logic [3:0] rdi_raw;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [2:0] st;
        logic [3:0] raw;
        string      tag;
    } exp_t;
    exp_t q[$];

    // Bench reference state derived from the requirements.
    logic [2:0] m_cand = '0;
    int         m_cnt  = 0;
    logic [2:0] m_held = '0;
    logic [3:0] m_raw  = '0;

    always #5 clk = ~clk;

    path_rdi_filter u0 (.*);

    function automatic int thr_of(input logic [1:0] s);
        case (s)
            2'b00: return 3;
            2'b01: return 5;
            2'b10: return 10;
            default: return 16;
        endcase
    endfunction

    task automatic check(input string tag, input logic [2:0] st, input logic [3:0] raw,
                         input logic [2:0] est, input logic [3:0] eraw);
        checks++;
        if (st !== est || raw !== eraw) begin
            failures++;
            $display("FAIL %s: status=%b raw=%b expected status=%b raw=%b", tag, st, raw, est, eraw);
        end
    endtask

    task automatic send(input logic [7:0] b, input string tag);
        logic [2:0] code;
        exp_t e;
        @(negedge clk);
        g1_byte  = b;
        g1_valid = 1'b1;
        code = enh_mode ? b[3:1] : {b[3], 2'b00};
        if (code != m_cand) m_cnt = 1;
        else if (m_cnt < 16) m_cnt++;
        m_cand = code;
        if (m_cnt >= thr_of(persist_sel)) m_held = code;
        m_raw = b[3:0];
        @(posedge clk);
        #1;
        e.st  = enh_mode ? m_held : {m_held[2], 2'b00};
        e.raw = m_raw;
        e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        g1_valid = 1'b0;
    endtask

    task automatic run(input logic [7:0] b, input int n, input string tag);
        for (int i = 0; i < n; i++) send(b, tag);
    endtask

    // Monitor: compares each result as it appears.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, rdi_status, rdi_raw, e.st, e.raw);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset", rdi_status, rdi_raw, 3'b000, 4'b0000);

        // R10: zero run from reset, default length 5
        run(8'h00, 6, "R10 zero run");

        // R3/R4/R6: default length 5, enhanced code 101 (byte bits 3:1)
        run(8'hAB, 4, "R4 before run complete");   // code 101, raw 1011
        send(8'hAB, "R4 run complete at 5 R6");
        check("R6 enhanced code", rdi_status, rdi_raw, 3'b101, 4'b1011);

        // R5: break one short of threshold, then a full run
        run(8'h04, 4, "R5 partial");              // code 010
        send(8'h06, "R5 break");                  // code 011
        run(8'h04, 4, "R5 restart partial");
        check("R5 still old", rdi_status, rdi_raw, 3'b101, 4'b0100);
        send(8'h04, "R5 restart complete");

        // R3 other lengths
        persist_sel = 2'b00;
        run(8'h0E, 3, "R3 length 3");             // code 111
        persist_sel = 2'b10;
        run(8'h02, 9, "R3 length 10 before");     // code 001
        send(8'h02, "R3 length 10 complete");
        persist_sel = 2'b11;
        run(8'h08, 15, "R3 length 16 before");    // code 100
        send(8'h08, "R3 length 16 complete");

        // R8: long run saturates, new code still needs full length
        run(8'h08, 40, "R8 long run");
        run(8'h0C, 15, "R8 new code short");      // code 110
        check("R8 no early load", rdi_status, rdi_raw, 3'b100, 4'b1100);
        send(8'h0C, "R8 new code complete");

        // R7: single-bit mode, bits 2:1 toggled inside run
        enh_mode = 1'b0;
        persist_sel = 2'b01;
        send(8'h00, "R7 bit3 low 1");
        send(8'h06, "R7 bit3 low 2");
        send(8'h02, "R7 bit3 low 3");
        send(8'h04, "R7 bit3 low 4");
        send(8'h01, "R7 bit3 low 5 complete");
        check("R7 primary only", rdi_status, rdi_raw, 3'b000, 4'b0001);
        run(8'h08, 2, "R7 bit3 high");
        run(8'h0E, 3, "R7 bit3 high toggled");

        // R9: no strobe, nothing moves
        repeat (6) @(negedge clk);
        check("R9 idle hold", rdi_status, rdi_raw, 3'b100, 4'b1110);

        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog: status=%b raw=%b expected run to finish", rdi_status, rdi_raw);
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule